// File: doc/BRIEF.md
# Four-Wire Serial Register Slave with Bus-Kind Lock

This block gives a camera sensor controller a byte-wide register store that a host reaches over a four-wire serial link: an active-low chip-select, a serial clock, a data input and a data output. Every transfer opens with a page byte. Its low seven bits pick one of several 256-byte pages, and its top bit picks the direction. A byte offset follows, and then any number of data bytes. Each data byte moves the offset on by one, and the offset wraps inside the page. All pins are oversampled by the system clock through two-stage synchronizers, so the serial clock must run well below the system clock.

The same pins can also carry a two-wire bus. The block watches for whichever bus shows its opening pattern first after reset, and it keeps that choice until the next reset. Once the two-wire bus has been recognised, the four-wire engine stays silent. A combinational tap port lets downstream logic read any register at any time.

Top module: `four_wire_regslave`

## Requirements
- R1: While chip-select is high, `sdo_oe` is low and the engine is idle. Every transfer starts again with a page byte after chip-select falls.
- R2: Bits travel least-significant first. `sdi` is taken on each rising edge of `sck` while chip-select is low.
- R3: A first byte with bit 7 clear and a value from 02h to 01h+PAGES (02h..06h by default) selects write access to page (value-2).
- R4: A first byte from 82h to 81h+PAGES selects read access to page (value-82h). Any other first byte makes the whole transfer ignored: no register changes and `sdo_oe` stays low.
- R5: The second byte sets the starting offset. Each complete data byte goes to the current offset, and the offset then increments, wrapping from FFh to 00h within the same page.
- R6: In a read, `sdo` presents the register at the current offset least-significant bit first. It changes only after falling `sck` edges and is valid at the following rising edge. `sdo_oe` is high through the data phase.
- R7: If chip-select rises before the eighth bit of a byte, that byte is discarded and no register is written.
- R8: `bus_kind` reads 0 after reset. It becomes 1 when chip-select falls first. It becomes 2 when `sdi` falls while `sck` and chip-select are both high first. After that it never changes until reset, and while it is 2 no four-wire transfer changes any register.
- R9: After reset, the register at page p, offset o holds ((p+1)·11h) XOR o.
- R10: `tap_data` shows the register at (`tap_page`, `tap_off`) combinationally. A page index of PAGES or more reads as 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are oversampled by it |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| bus_kind | output | 2 | 0 undecided, 1 four-wire, 2 two-wire |
| tap_page | input | $clog2(PAGES) | Page index for the settings tap |
| tap_off | input | 8 | Offset for the settings tap |
| tap_data | output | 8 | Register value at the tap address |

## Verification
The hardest state to reach from the ports is the two-wire lock. It has to be the very first event after reset: `sdi` must fall while both `sck` and chip-select rest high, before chip-select has ever been asserted. The bench gets there by applying a fresh reset, producing only that start pattern, and then running a full four-wire write. It checks through the tap that nothing changed. The offset wrap and the chip-select abort in the middle of a byte are reached by starting writes at offset FEh and by raising chip-select after four bits, with a clean transfer afterwards to show that the engine recovered.

// File: rtl/regslave_pkg.sv
package regslave_pkg;

  localparam int BYTE_W = 8;
  localparam int PAGE_BYTES = 256;
  localparam logic [6:0] FIRST_CODE = 7'h02;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_FOUR = 2'd1,
    KIND_TWO  = 2'd2
  } bus_kind_t;

  typedef enum logic [1:0] {
    PH_PAGE,
    PH_OFF,
    PH_DATA,
    PH_SKIP
  } phase_t;

  typedef struct packed {
    logic       valid;
    logic       rd;
    logic [6:0] idx;
  } page_sel_t;

  // Split a page byte into direction, page index and validity.
  function automatic page_sel_t decode_page(input logic [7:0] code, input int pages);
    page_sel_t r;
    r.rd    = code[7];
    r.idx   = code[6:0] - FIRST_CODE;
    r.valid = (code[6:0] >= FIRST_CODE) && (int'(r.idx) < pages);
    return r;
  endfunction

  // Reset content of one register.
  function automatic logic [7:0] init_byte(input int page, input int off);
    logic [7:0] tag;
    tag = 8'((page + 1) * 17);
    return tag ^ 8'(off);
  endfunction

endpackage

// File: rtl/regslave_sync.sv
module regslave_sync #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] level,
  output logic [N-1:0] prev
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [2:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= {3{RST_VAL[i]}};
      else        sh <= {sh[1:0], din[i]};
    end
    assign level[i] = sh[1];
    assign prev[i]  = sh[2];
  end
endmodule

// File: rtl/regslave_arbiter.sv
module regslave_arbiter
  import regslave_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cs_fall,
  input  logic      start_seen,
  output bus_kind_t kind
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind <= KIND_NONE;
    end else if (kind == KIND_NONE) begin
      if (cs_fall)         kind <= KIND_FOUR;
      else if (start_seen) kind <= KIND_TWO;
    end
  end
endmodule

// File: rtl/regslave_engine.sv
module regslave_engine
  import regslave_pkg::*;
#(
  parameter int PAGES = 5,
  parameter int PG_W  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            cs_n_lvl,
  input  logic            sck_rise,
  input  logic            sck_fall,
  input  logic            sdi_bit,
  input  logic [7:0]      rd_data,
  output logic            cs_act,
  output logic            fall_ev,
  output logic            wr_fire,
  output logic [PG_W-1:0] cur_page,
  output logic [7:0]      cur_off,
  output logic [7:0]      wr_data,
  output logic            sdo,
  output logic            sdo_oe
);
  phase_t     phase;
  logic [2:0] bit_cnt;
  logic [7:0] shreg;
  logic [7:0] tx;
  logic       is_rd;
  logic       rise_ev;
  logic       byte_done;
  logic [7:0] next_byte;
  page_sel_t  sel;

  assign cs_act    = en & ~cs_n_lvl;
  assign rise_ev   = cs_act & sck_rise;
  assign fall_ev   = cs_act & sck_fall;
  assign next_byte = {sdi_bit, shreg[7:1]};
  assign byte_done = rise_ev && (bit_cnt == 3'd7);
  assign sel       = decode_page(next_byte, PAGES);
  assign wr_fire   = byte_done && (phase == PH_DATA) && !is_rd;
  assign wr_data   = next_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_PAGE;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx       <= '0;
      is_rd    <= 1'b0;
      cur_page <= '0;
      cur_off  <= '0;
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
    end else if (!cs_act) begin
      phase   <= PH_PAGE;
      bit_cnt <= '0;
      sdo_oe  <= 1'b0;
    end else begin
      if (rise_ev) begin
        shreg   <= next_byte;
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (byte_done) begin
        case (phase)
          PH_PAGE: begin
            if (sel.valid) begin
              is_rd    <= sel.rd;
              cur_page <= PG_W'(sel.idx);
              phase    <= PH_OFF;
            end else begin
              phase <= PH_SKIP;
            end
          end
          PH_OFF: begin
            cur_off <= next_byte;
            phase   <= PH_DATA;
            sdo_oe  <= is_rd;
          end
          PH_DATA: cur_off <= cur_off + 8'd1;
          default: ;
        endcase
      end
      if (fall_ev && (phase == PH_DATA) && is_rd) begin
        if (bit_cnt == 3'd0) begin
          sdo <= rd_data[0];
          tx  <= {1'b0, rd_data[7:1]};
        end else begin
          sdo <= tx[0];
          tx  <= {1'b0, tx[7:1]};
        end
      end
    end
  end
endmodule

// File: rtl/regslave_bank.sv
module regslave_bank
  import regslave_pkg::*;
#(
  parameter int PAGES = 5,
  parameter int PG_W  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [PG_W-1:0] w_page,
  input  logic [7:0]      w_off,
  input  logic [7:0]      w_data,
  input  logic [PG_W-1:0] a_page,
  input  logic [7:0]      a_off,
  output logic [7:0]      a_data,
  input  logic [PG_W-1:0] b_page,
  input  logic [7:0]      b_off,
  output logic [7:0]      b_data
);
  localparam int DEPTH = PAGES * PAGE_BYTES;
  localparam logic [PG_W:0] NPAGES = (PG_W + 1)'(PAGES);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_byte(i / PAGE_BYTES, i % PAGE_BYTES);
    end else if (we) begin
      mem[{w_page, w_off}] <= w_data;
    end
  end

  assign a_data = ({1'b0, a_page} < NPAGES) ? mem[{a_page, a_off}] : 8'h00;
  assign b_data = ({1'b0, b_page} < NPAGES) ? mem[{b_page, b_off}] : 8'h00;
endmodule

// File: rtl/four_wire_regslave.sv
module four_wire_regslave
  import regslave_pkg::*;
#(
  parameter int PAGES = 5,
  localparam int PG_W = $clog2(PAGES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            sck,
  input  logic            sdi,
  output logic            sdo,
  output logic            sdo_oe,
  output logic [1:0]      bus_kind,
  input  logic [PG_W-1:0] tap_page,
  input  logic [7:0]      tap_off,
  output logic [7:0]      tap_data
);
  logic [2:0] lvl, prv;
  logic cs_s, sck_s, sdi_s;
  logic cs_fall_ev, sck_rise_ev, sck_fall_raw, start_ev;
  logic cs_act, sck_fall_ev, wr_fire;
  logic [PG_W-1:0] cur_page;
  logic [7:0] cur_off, wr_data, rd_data;
  bus_kind_t kind;

  regslave_sync #(.N(3), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({cs_n, sck, sdi}), .level(lvl), .prev(prv)
  );

  assign cs_s  = lvl[2];
  assign sck_s = lvl[1];
  assign sdi_s = lvl[0];

  assign cs_fall_ev   = prv[2] & ~cs_s;
  assign sck_rise_ev  = ~prv[1] & sck_s;
  assign sck_fall_raw = prv[1] & ~sck_s;
  assign start_ev     = prv[0] & ~sdi_s & sck_s & prv[1] & cs_s;

  regslave_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall_ev), .start_seen(start_ev), .kind(kind)
  );

  regslave_engine #(.PAGES(PAGES), .PG_W(PG_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .en(kind == KIND_FOUR), .cs_n_lvl(cs_s),
    .sck_rise(sck_rise_ev), .sck_fall(sck_fall_raw), .sdi_bit(sdi_s),
    .rd_data(rd_data), .cs_act(cs_act), .fall_ev(sck_fall_ev), .wr_fire(wr_fire),
    .cur_page(cur_page), .cur_off(cur_off), .wr_data(wr_data),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  regslave_bank #(.PAGES(PAGES), .PG_W(PG_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(wr_fire), .w_page(cur_page), .w_off(cur_off),
    .w_data(wr_data), .a_page(cur_page), .a_off(cur_off), .a_data(rd_data),
    .b_page(tap_page), .b_off(tap_off), .b_data(tap_data)
  );

  assign bus_kind = kind;
endmodule

// File: rtl/regslave_checks.sv
module regslave_checks #(
  parameter int PAGES = 5,
  parameter int PG_W  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_act,
  input logic            sck_fall_ev,
  input logic            wr_fire,
  input logic [PG_W-1:0] wr_page,
  input logic [7:0]      wr_off,
  input logic [1:0]      bus_kind,
  input logic            sdo,
  input logic            sdo_oe
);
  localparam logic [PG_W:0] NP = (PG_W + 1)'(PAGES);

  assert_oe_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !sdo_oe);

  assert_page_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> ({1'b0, wr_page} < NP));

  assert_offset_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (wr_off == $past(wr_off) + 8'd1));

  assert_sdo_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall_ev |=> $stable(sdo));

  assert_kind_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_kind != 2'd0) |=> $stable(bus_kind));

  assert_no_write_unless_four_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (bus_kind == 2'd1));

  assert_kind_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_kind != 2'd3);
endmodule

bind four_wire_regslave regslave_checks #(.PAGES(PAGES), .PG_W(PG_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_fall_ev(sck_fall_ev),
  .wr_fire(wr_fire), .wr_page(cur_page), .wr_off(cur_off),
  .bus_kind(bus_kind), .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/tb_four_wire_regslave.sv
module tb_four_wire_regslave;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b1, sdi = 1'b1;
  logic sdo, sdo_oe;
  logic [1:0] bus_kind;
  logic [2:0] tap_page = '0;
  logic [7:0] tap_off = '0;
  logic [7:0] tap_data;
  int checks = 0, errors = 0;
  logic [7:0] rx;

  always #4 clk = ~clk;

  four_wire_regslave dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .bus_kind(bus_kind),
    .tap_page(tap_page), .tap_off(tap_off), .tap_data(tap_data)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // Reset content: page index repeated in both nibbles (plus one), XOR offset.
  function automatic logic [7:0] reset_val(input int p, input int o);
    logic [3:0] n;
    n = 4'(p + 1);
    return {n, n} ^ 8'(o);
  endfunction

  task automatic do_reset();
    cs_n = 1'b1; sck = 1'b1; sdi = 1'b1;
    rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(4);
  endtask

  task automatic peek(input int p, input int o, output logic [7:0] v);
    tap_page = 3'(p); tap_off = 8'(o); tick(1); v = tap_data;
  endtask

  task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] got);
    for (int i = 0; i < 8; i++) begin
      sck = 1'b0; sdi = tx[i]; tick(HALF);
      got[i] = sdo; sck = 1'b1; tick(HALF);
    end
  endtask

  task automatic open_tx();  cs_n = 1'b0; tick(6); endtask
  task automatic close_tx(); tick(2); cs_n = 1'b1; tick(8); endtask

  task automatic t_reset_state();
    logic [7:0] v;
    check("R8 kind after reset", {6'd0, bus_kind}, 8'h00);
    check("R1 oe after reset", {7'd0, sdo_oe}, 8'h00);
    peek(0, 0, v);    check("R9 init p0 o00", v, reset_val(0, 0));
    peek(4, 255, v);  check("R9 init p4 oFF", v, reset_val(4, 255));
    peek(2, 16, v);   check("R10 tap p2 o10", v, reset_val(2, 16));
    peek(5, 3, v);    check("R10 tap page out of range", v, 8'h00);
  endtask

  task automatic t_write_burst();
    logic [7:0] v;
    open_tx();
    xfer_byte(8'h04, rx); xfer_byte(8'h10, rx);
    xfer_byte(8'hA5, rx); xfer_byte(8'h3C, rx);
    close_tx();
    check("R8 kind four-wire", {6'd0, bus_kind}, 8'h01);
    peek(2, 16, v); check("R3 write p2 o10", v, 8'hA5);
    peek(2, 17, v); check("R5 increment p2 o11", v, 8'h3C);
    peek(2, 18, v); check("R5 untouched p2 o12", v, reset_val(2, 18));
  endtask

  task automatic t_write_wrap();
    logic [7:0] v;
    open_tx();
    xfer_byte(8'h06, rx); xfer_byte(8'hFE, rx);
    xfer_byte(8'h01, rx); xfer_byte(8'h02, rx); xfer_byte(8'h03, rx);
    close_tx();
    peek(4, 254, v); check("R5 wrap p4 oFE", v, 8'h01);
    peek(4, 255, v); check("R5 wrap p4 oFF", v, 8'h02);
    peek(4, 0, v);   check("R5 wrap p4 o00", v, 8'h03);
    peek(3, 0, v);   check("R5 wrap stays in page", v, reset_val(3, 0));
  endtask

  task automatic t_read();
    open_tx();
    xfer_byte(8'h84, rx); xfer_byte(8'h10, rx);
    xfer_byte(8'h00, rx); check("R6 read p2 o10", rx, 8'hA5);
    check("R6 oe in data phase", {7'd0, sdo_oe}, 8'h01);
    xfer_byte(8'h00, rx); check("R6 read p2 o11", rx, 8'h3C);
    close_tx();
    check("R1 oe after cs high", {7'd0, sdo_oe}, 8'h00);
    open_tx();
    xfer_byte(8'h86, rx); xfer_byte(8'hFF, rx);
    xfer_byte(8'h00, rx); check("R6 read p4 oFF", rx, 8'h02);
    xfer_byte(8'h00, rx); check("R5 read wrap p4 o00", rx, 8'h03);
    close_tx();
    sdi = 1'b0; tick(8); sdi = 1'b1; tick(8);
    check("R8 start pattern after lock", {6'd0, bus_kind}, 8'h01);
  endtask

  task automatic t_ignored_codes();
    logic [7:0] v;
    open_tx();
    xfer_byte(8'h07, rx); xfer_byte(8'h10, rx); xfer_byte(8'h77, rx);
    check("R4 oe low for bad code", {7'd0, sdo_oe}, 8'h00);
    close_tx();
    peek(2, 16, v); check("R4 bad code no write p2", v, 8'hA5);
    peek(0, 16, v); check("R4 bad code no write p0", v, reset_val(0, 16));
    open_tx();
    xfer_byte(8'h81, rx); xfer_byte(8'h10, rx); xfer_byte(8'h00, rx);
    check("R4 oe low for bad read code", {7'd0, sdo_oe}, 8'h00);
    close_tx();
  endtask

  task automatic t_partial_byte();
    logic [7:0] v;
    open_tx();
    xfer_byte(8'h02, rx); xfer_byte(8'h20, rx);
    for (int i = 0; i < 4; i++) begin
      sck = 1'b0; sdi = 1'b0; tick(HALF); sck = 1'b1; tick(HALF);
    end
    close_tx();
    peek(0, 32, v); check("R7 partial byte dropped", v, reset_val(0, 32));
    open_tx();
    xfer_byte(8'h02, rx); xfer_byte(8'h21, rx); xfer_byte(8'h99, rx);
    close_tx();
    peek(0, 33, v); check("R1 fresh transfer after abort", v, 8'h99);
    peek(0, 32, v); check("R2 neighbour unchanged", v, reset_val(0, 32));
  endtask

  task automatic t_two_wire_lock();
    logic [7:0] v;
    do_reset();
    sdi = 1'b0; tick(8);
    check("R8 kind two-wire", {6'd0, bus_kind}, 8'h02);
    sdi = 1'b1; tick(4);
    open_tx();
    xfer_byte(8'h02, rx); xfer_byte(8'h00, rx); xfer_byte(8'hEE, rx);
    check("R8 oe silent in two-wire", {7'd0, sdo_oe}, 8'h00);
    close_tx();
    peek(0, 0, v); check("R8 no write in two-wire", v, reset_val(0, 0));
    check("R8 kind still two-wire", {6'd0, bus_kind}, 8'h02);
    do_reset();
    check("R8 kind cleared by reset", {6'd0, bus_kind}, 8'h00);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    t_reset_state();
    t_write_burst();
    t_write_wrap();
    t_read();
    t_ignored_codes();
    t_partial_byte();
    t_two_wire_lock();
    finish_run();
  end
endmodule